// File: doc/BRIEF.md
# Masked Ternary Search Array

The block holds a table of 136-bit ternary entries, each split into an even 68-bit half and an odd 68-bit half at two adjacent locations. A search key is presented over two consecutive cycles on a 68-bit bus. The first cycle carries the even half and an index that picks a pair of global mask registers. The second cycle carries the odd half and an index that picks a pair of comparand registers. The key is compared with every valid entry under the combined global and local masks. The lowest-numbered matching entry wins, and its even location is reported one cycle after the second key cycle has been registered.

The full key is also saved into the indexed comparand pair, where a read port makes it visible for later use. A single write port loads entry halves, local mask halves, global mask halves and per-entry valid bits. Writes take effect for the next search. Searches can be issued back to back, with a new first cycle every two clocks, and their results come out in a pipeline.

Top module: `ternary_search_array`

## Requirements
- R1: After an active-low reset, rslt_vld_o, hit_o and miss_o are 0, hit_addr_o is 0, every comparand pair reads 0, all entries are invalid, and all global and local mask bits are 1.
- R2: A search is a cycle-A strobe carrying key bits [67:0], followed on the very next cycle by a cycle-B strobe carrying key bits [135:68]. Its result is visible (rslt_vld_o high for one cycle) after the second rising edge following the cycle-B edge.
- R3: A key bit is compared only where both the selected global mask bit and the entry's local mask bit are 1. A 0 in either makes that bit don't-care.
- R4: gm_idx_i, sampled in cycle A, selects the global mask pair used for that search. Pair p's even half covers key bits [67:0] and its odd half covers key bits [135:68].
- R5: When several entries match, the one with the lowest entry number e wins. hit_addr_o reports location 2*e, so bit 0 is always 0.
- R6: Invalid entries never match. Every result has exactly one of hit_o and miss_o set. miss_o is set when no valid entry matches, and then hit_addr_o is 0.
- R7: At an accepted cycle B, comparand pair cmp_idx_i is loaded with {odd half, even half} of the key. cmp_odd_o/cmp_even_o show pair cmp_rd_idx_i combinationally.
- R8: Write port encoding, selected by wr_kind_i: 0 writes entry data, 1 writes the local mask, 2 writes the global mask, 3 writes the valid bit. wr_addr_i[0] picks the half (0 even, 1 odd). The remaining bits of wr_addr_i pick the entry, or for kind 2 bits [2:1] pick the mask pair. Kind 3 sets the entry's valid bit to wr_data_i[0] and ignores wr_addr_i[0]. A write lands at its clock edge.
- R9: Searches may run back to back, with A,B,A,B on consecutive cycles, and each one yields its own result in order.
- R10: A cycle-B strobe that does not directly follow a cycle-A strobe is ignored. It produces no result and writes no comparand pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| srch_a_i | input | 1 | Search cycle A strobe |
| srch_b_i | input | 1 | Search cycle B strobe |
| key_i | input | 68 | Key half (even in A, odd in B) |
| gm_idx_i | input | 2 | Global mask pair index (cycle A) |
| cmp_idx_i | input | 2 | Comparand pair index (cycle B) |
| wr_en_i | input | 1 | Write strobe |
| wr_kind_i | input | 2 | Write target kind |
| wr_addr_i | input | 7 | Write location |
| wr_data_i | input | 68 | Write data |
| cmp_rd_idx_i | input | 2 | Comparand pair read index |
| cmp_even_o | output | 68 | Even half of the read comparand pair |
| cmp_odd_o | output | 68 | Odd half of the read comparand pair |
| rslt_vld_o | output | 1 | Search result valid |
| hit_o | output | 1 | Match found |
| miss_o | output | 1 | No match |
| hit_addr_o | output | 7 | Even location of the winning entry |

## Verification
The assertions assume that a cycle-A strobe never appears on two consecutive cycles and that no write is issued in a cycle-A cycle. Under these two rules the global mask and the entries stay fixed between the two key halves. The bench issues every search through one task that drives A and then B on adjacent cycles. Writes are placed only in idle cycles or alongside cycle B, and deliberately orphaned B strobes are the only departure from the A-B pairing.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int HALF_W = 68;
  localparam int ENT_W  = 2 * HALF_W;

  typedef enum logic [1:0] {
    WK_DATA  = 2'd0,
    WK_LMASK = 2'd1,
    WK_GMASK = 2'd2,
    WK_VALID = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/tsa_regs.sv
module tsa_regs
  import tsa_pkg::*;
#(
  parameter int HW     = HALF_W,
  parameter int GM_N   = 4,
  parameter int CMP_N  = 4,
  localparam int GMI_W = $clog2(GM_N),
  localparam int CMI_W = $clog2(CMP_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gm_we_i,
  input  logic [GMI_W:0]    gm_waddr_i,
  input  logic [HW-1:0]     gm_wdata_i,
  input  logic [GMI_W-1:0]  gm_rd_idx_i,
  output logic [2*HW-1:0]   gmask_o,
  input  logic              cmp_we_i,
  input  logic [CMI_W-1:0]  cmp_idx_i,
  input  logic [2*HW-1:0]   cmp_data_i,
  input  logic [CMI_W-1:0]  cmp_rd_idx_i,
  output logic [2*HW-1:0]   cmp_o
);
  logic [2*HW-1:0] gm_q  [GM_N];
  logic [2*HW-1:0] cmp_q [CMP_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < GM_N; p++) gm_q[p] <= '1;
    end else if (gm_we_i) begin
      if (gm_waddr_i[0]) gm_q[gm_waddr_i[GMI_W:1]][2*HW-1:HW] <= gm_wdata_i;
      else               gm_q[gm_waddr_i[GMI_W:1]][HW-1:0]    <= gm_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < CMP_N; p++) cmp_q[p] <= '0;
    end else if (cmp_we_i) begin
      cmp_q[cmp_idx_i] <= cmp_data_i;
    end
  end

  assign gmask_o = gm_q[gm_rd_idx_i];
  assign cmp_o   = cmp_q[cmp_rd_idx_i];

  // R7: accepted key lands in the indexed comparand pair
  a_r7_cmp_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_we_i |=> (cmp_q[$past(cmp_idx_i)] == $past(cmp_data_i)));
endmodule

// File: rtl/tsa_store.sv
module tsa_store
  import tsa_pkg::*;
#(
  parameter int HW     = HALF_W,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LOC_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  wr_kind_e         wr_kind_i,
  input  logic [LOC_W-1:0] wr_addr_i,
  input  logic [HW-1:0]    wr_data_i,
  input  logic [2*HW-1:0]  key_i,
  input  logic [2*HW-1:0]  gmask_i,
  output logic [DEPTH-1:0] match_o
);
  logic [IDX_W-1:0] wr_ent;
  assign wr_ent = wr_addr_i[LOC_W-1:1];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [2*HW-1:0] data_q, lm_q;
    logic            vld_q;
    logic            sel;

    assign sel = wr_en_i && (wr_ent == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q <= '0;
        lm_q   <= '1;
        vld_q  <= 1'b0;
      end else if (sel) begin
        case (wr_kind_i)
          WK_DATA:
            if (wr_addr_i[0]) data_q[2*HW-1:HW] <= wr_data_i;
            else              data_q[HW-1:0]    <= wr_data_i;
          WK_LMASK:
            if (wr_addr_i[0]) lm_q[2*HW-1:HW] <= wr_data_i;
            else              lm_q[HW-1:0]    <= wr_data_i;
          WK_VALID: vld_q <= wr_data_i[0];
          default: ;
        endcase
      end
    end

    // a bit takes part only when both masks enable it
    assign match_o[i] = vld_q && ~|((key_i ^ data_q) & gmask_i & lm_q);

    // R8: valid write sets the entry's valid bit from data bit 0
    a_r8_valid_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_kind_i == WK_VALID && wr_ent == IDX_W'(i))
        |=> (vld_q == $past(wr_data_i[0])));
  end
endmodule

// File: rtl/tsa_prio.sv
module tsa_prio #(
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chk_i,
  input  logic [DEPTH-1:0] match_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  logic [DEPTH-1:0] below;
  assign below = (DEPTH'(1) << idx_o) - DEPTH'(1);

  // R5: winner matches and nothing lower matches
  a_r5_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_i && found_o) |-> (match_i[idx_o] && ((match_i & below) == '0)));
  // R6: no winner only when nothing matched
  a_r6_none_found: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_i && !found_o) |-> (match_i == '0));
endmodule

// File: rtl/ternary_search_array.sv
module ternary_search_array
  import tsa_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int HW     = HALF_W,
  parameter int GM_N   = 4,
  parameter int CMP_N  = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LOC_W = IDX_W + 1,
  localparam int GMI_W = $clog2(GM_N),
  localparam int CMI_W = $clog2(CMP_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srch_a_i,
  input  logic             srch_b_i,
  input  logic [HW-1:0]    key_i,
  input  logic [GMI_W-1:0] gm_idx_i,
  input  logic [CMI_W-1:0] cmp_idx_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_kind_i,
  input  logic [LOC_W-1:0] wr_addr_i,
  input  logic [HW-1:0]    wr_data_i,
  input  logic [CMI_W-1:0] cmp_rd_idx_i,
  output logic [HW-1:0]    cmp_even_o,
  output logic [HW-1:0]    cmp_odd_o,
  output logic             rslt_vld_o,
  output logic             hit_o,
  output logic             miss_o,
  output logic [LOC_W-1:0] hit_addr_o
);
  wr_kind_e         kind;
  logic             a_pend_q, b_ok;
  logic [HW-1:0]    key_a_q;
  logic [GMI_W-1:0] gm_idx_q;
  logic [2*HW-1:0]  key_full, gmask, cmp_rd;
  logic [DEPTH-1:0] match, match_q;
  logic             mvld_q, found;
  logic [IDX_W-1:0] win_idx;

  assign kind     = wr_kind_e'(wr_kind_i);
  assign b_ok     = srch_b_i && a_pend_q;
  assign key_full = {key_i, key_a_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_pend_q <= 1'b0;
      key_a_q  <= '0;
      gm_idx_q <= '0;
    end else begin
      a_pend_q <= srch_a_i;
      if (srch_a_i) begin
        key_a_q  <= key_i;
        gm_idx_q <= gm_idx_i;
      end
    end
  end

  tsa_regs #(.HW(HW), .GM_N(GM_N), .CMP_N(CMP_N)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .gm_we_i      (wr_en_i && kind == WK_GMASK),
    .gm_waddr_i   (wr_addr_i[GMI_W:0]),
    .gm_wdata_i   (wr_data_i),
    .gm_rd_idx_i  (gm_idx_q),
    .gmask_o      (gmask),
    .cmp_we_i     (b_ok),
    .cmp_idx_i    (cmp_idx_i),
    .cmp_data_i   (key_full),
    .cmp_rd_idx_i (cmp_rd_idx_i),
    .cmp_o        (cmp_rd)
  );

  assign cmp_even_o = cmp_rd[HW-1:0];
  assign cmp_odd_o  = cmp_rd[2*HW-1:HW];

  tsa_store #(.HW(HW), .DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_kind_i (kind),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .key_i     (key_full),
    .gmask_i   (gmask),
    .match_o   (match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '0;
      mvld_q  <= 1'b0;
    end else begin
      mvld_q <= b_ok;
      if (b_ok) match_q <= match;
    end
  end

  tsa_prio #(.DEPTH(DEPTH)) u_prio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .chk_i   (mvld_q),
    .match_i (match_q),
    .found_o (found),
    .idx_o   (win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rslt_vld_o <= 1'b0;
      hit_o      <= 1'b0;
      miss_o     <= 1'b0;
      hit_addr_o <= '0;
    end else begin
      rslt_vld_o <= mvld_q;
      hit_o      <= mvld_q && found;
      miss_o     <= mvld_q && !found;
      hit_addr_o <= (mvld_q && found) ? {win_idx, 1'b0} : '0;
    end
  end

  // R2: accepted search reports two edges after cycle B
  a_r2_result_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_ok |=> ##1 rslt_vld_o);
  // R10: every result traces back to an accepted cycle B
  a_r10_no_orphan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rslt_vld_o |-> $past(b_ok, 2));
  // R6: exactly one of hit/miss per result
  a_r6_hit_xor_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rslt_vld_o |-> (hit_o ^ miss_o));
  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rslt_vld_o |-> (!hit_o && !miss_o));
  // R9: input rule, cycle A at most every other clock
  a_r9_a_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srch_a_i |=> !srch_a_i);
endmodule

// File: tb/ternary_search_array_bench.sv
module ternary_search_array_bench;
  localparam int DEPTH = 64;
  localparam int HW    = 68;
  localparam int LW    = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          srch_a = 0, srch_b = 0, wr_en = 0;
  logic [HW-1:0] key = '0, wr_data = '0;
  logic [1:0]    gm_idx = '0, cmp_idx = '0, wr_kind = '0, cmp_rd_idx = '0;
  logic [LW-1:0] wr_addr = '0;
  logic [HW-1:0] cmp_even, cmp_odd;
  logic          rslt_vld, hit, miss;
  logic [LW-1:0] hit_addr;

  ternary_search_array u_ternary_search_array (
    .clk_i(clk), .rst_ni(rst_n), .srch_a_i(srch_a), .srch_b_i(srch_b),
    .key_i(key), .gm_idx_i(gm_idx), .cmp_idx_i(cmp_idx), .wr_en_i(wr_en),
    .wr_kind_i(wr_kind), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .cmp_rd_idx_i(cmp_rd_idx), .cmp_even_o(cmp_even), .cmp_odd_o(cmp_odd),
    .rslt_vld_o(rslt_vld), .hit_o(hit), .miss_o(miss), .hit_addr_o(hit_addr)
  );

  // behavioural reference
  logic [135:0] m_data [DEPTH];
  logic [135:0] m_lm   [DEPTH];
  bit           m_vld  [DEPTH];
  logic [135:0] m_gm [4];
  logic [135:0] m_cmp [4];
  logic [67:0]  m_keya;
  int           m_gi;
  bit           m_pend;

  typedef struct { int due; bit hit; int addr; } exp_t;
  exp_t q[$];

  int    cyc = 0, checks = 0, errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  task automatic chk(bit ok, string req, string what, logic [135:0] act, logic [135:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_lm[i] = '1; m_vld[i] = 0; end
    for (int p = 0; p < 4; p++) begin m_gm[p] = '1; m_cmp[p] = '0; end
    m_keya = '0; m_gi = 0; m_pend = 0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (srch_b && m_pend) begin
        logic [135:0] k;
        exp_t e;
        k = {key, m_keya};
        e.due = cyc + 1; e.hit = 0; e.addr = 0;
        for (int i = 0; i < DEPTH; i++)
          if (!e.hit && m_vld[i] && (((k ^ m_data[i]) & m_gm[m_gi] & m_lm[i]) == '0)) begin
            e.hit = 1; e.addr = 2 * i;
          end
        q.push_back(e);
        m_cmp[cmp_idx] = k;
      end
      m_pend = srch_a;
      if (srch_a) begin m_keya = key; m_gi = gm_idx; end
      if (wr_en) begin
        int ent;
        ent = int'(wr_addr) >> 1;
        case (wr_kind)
          2'd0: if (wr_addr[0]) m_data[ent][135:68] = wr_data; else m_data[ent][67:0] = wr_data;
          2'd1: if (wr_addr[0]) m_lm[ent][135:68] = wr_data; else m_lm[ent][67:0] = wr_data;
          2'd2: if (wr_addr[0]) m_gm[wr_addr[2:1]][135:68] = wr_data; else m_gm[wr_addr[2:1]][67:0] = wr_data;
          default: m_vld[ent] = wr_data[0];
        endcase
      end
    end
  end

  // compare every clock, mid high phase
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      bit ev, eh; int ea;
      ev = 0; eh = 0; ea = 0;
      if (q.size() > 0 && q[0].due == cyc) begin
        ev = 1; eh = q[0].hit; ea = q[0].addr;
        void'(q.pop_front());
      end
      chk(rslt_vld == ev, cur_req, "rslt_vld", 136'(rslt_vld), 136'(ev));
      chk(hit == eh, cur_req, "hit", 136'(hit), 136'(eh));
      chk(miss == (ev && !eh), cur_req, "miss", 136'(miss), 136'(ev && !eh));
      chk(hit_addr == LW'(ea), cur_req, "hit_addr", 136'(hit_addr), 136'(ea));
      chk({cmp_odd, cmp_even} == m_cmp[cmp_rd_idx], "R7", "comparand",
          {cmp_odd, cmp_even}, m_cmp[cmp_rd_idx]);
    end
  end

  task automatic nxt();
    @(negedge clk);
    srch_a = 0; srch_b = 0; wr_en = 0;
    cmp_rd_idx = cmp_rd_idx + 2'd1;
  endtask

  task automatic write(logic [1:0] k, int a, logic [67:0] d);
    nxt(); wr_en = 1; wr_kind = k; wr_addr = LW'(a); wr_data = d;
  endtask

  task automatic put_entry(int e, logic [135:0] d, logic [135:0] lm);
    write(2'd0, 2*e, d[67:0]);   write(2'd0, 2*e+1, d[135:68]);
    write(2'd1, 2*e, lm[67:0]);  write(2'd1, 2*e+1, lm[135:68]);
    write(2'd3, 2*e, 68'd1);
  endtask

  task automatic set_gm(int p, logic [135:0] m);
    write(2'd2, 2*p, m[67:0]); write(2'd2, 2*p+1, m[135:68]);
  endtask

  // search, optionally with a write alongside cycle B
  task automatic search(logic [135:0] k, int gi, int ci, bit bw = 0,
                        logic [1:0] bk = 0, int ba = 0, logic [67:0] bd = 0);
    nxt(); srch_a = 1; key = k[67:0]; gm_idx = 2'(gi);
    nxt(); srch_b = 1; key = k[135:68]; cmp_idx = 2'(ci);
    if (bw) begin wr_en = 1; wr_kind = bk; wr_addr = LW'(ba); wr_data = bd; end
  endtask

  function automatic logic [135:0] rnd136();
    logic [159:0] t;
    t = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    return t[135:0];
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [135:0] d0, d1;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!rslt_vld && !hit && !miss, "R1", "flags", {hit, miss, rslt_vld}, 136'd0);
    chk(hit_addr == '0, "R1", "hit_addr", 136'(hit_addr), 136'd0);
    for (int p = 0; p < 4; p++) begin
      cmp_rd_idx = 2'(p); #1;
      chk({cmp_odd, cmp_even} == '0, "R1", "comparand", {cmp_odd, cmp_even}, 136'd0);
    end
    rst_n = 1;
    nxt();

    // R6: empty table misses
    cur_req = "R6";
    search(136'h1234, 0, 1); nxt(); nxt();

    // R5/R8: duplicate entries, lowest wins
    cur_req = "R8";
    d0 = rnd136();
    put_entry(9, d0, '1);
    put_entry(5, d0, '1);
    put_entry(40, d0, '1);
    cur_req = "R5";
    search(d0, 0, 2); nxt(); nxt();           // expect location 10
    cur_req = "R8";
    write(2'd3, 11, 68'd0);                   // invalidate entry 5 via odd address
    cur_req = "R6";
    search(d0, 0, 3); nxt(); nxt();           // expect location 18

    // R2: odd half matters
    cur_req = "R2";
    search(d0 ^ (136'd1 << 100), 0, 0); nxt(); nxt();
    search(d0 ^ (136'd1 << 3), 0, 0); nxt(); nxt();

    // R3: local mask don't-care
    cur_req = "R3";
    d1 = rnd136();
    put_entry(2, d1, ~(136'd1 << 70));
    search(d1 ^ (136'd1 << 70), 0, 1); nxt(); nxt();
    search(d1 ^ (136'd1 << 71), 0, 1); nxt(); nxt();

    // R4: global mask pair selection
    cur_req = "R4";
    set_gm(1, ~(136'd1 << 20 | 136'd1 << 120));
    search(d0 ^ (136'd1 << 120), 0, 2); nxt(); nxt();
    search(d0 ^ (136'd1 << 120), 1, 2); nxt(); nxt();
    search(d0 ^ (136'd1 << 20), 1, 2); nxt(); nxt();

    // R10: orphan cycle B
    cur_req = "R10";
    nxt(); srch_b = 1; key = '1; cmp_idx = 2'd0;
    nxt(); nxt(); nxt(); nxt(); nxt();

    // R9: back-to-back with writes beside cycle B
    cur_req = "R9";
    set_gm(2, ~(rnd136() & rnd136() & rnd136()));
    set_gm(3, ~(rnd136() & rnd136()));
    for (int i = 0; i < DEPTH; i++)
      put_entry(i, rnd136(), ~(rnd136() & rnd136() & rnd136() & rnd136()));
    for (int it = 0; it < 400; it++) begin
      int r, e;
      logic [135:0] k;
      r = $urandom_range(0, 9);
      e = $urandom_range(0, DEPTH - 1);
      k = m_data[e];
      if ($urandom_range(0, 1) == 1) k = k ^ (136'd1 << $urandom_range(0, 135));
      if (r < 6) begin
        if (r == 0)
          search(k, $urandom_range(0, 3), $urandom_range(0, 3), 1,
                 2'($urandom_range(0, 3)), $urandom_range(0, 2*DEPTH-1), 68'($urandom()));
        else
          search(k, $urandom_range(0, 3), $urandom_range(0, 3));
      end else if (r < 8) begin
        write(2'($urandom_range(0, 3)), $urandom_range(0, 2*DEPTH-1), rnd136()[67:0]);
      end else begin
        nxt();
      end
    end
    repeat (4) nxt();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule